// File: doc/BRIEF.md
# LAN Controller Register Access Bridge

This block sits between a host memory-mapped window and an attached LAN controller whose internal 16-bit registers are reached through two ports: an address port, which selects a register, and a data port, which reads or writes the selected register. The host stages a 16-bit value in a write latch and picks the port and the direction in a control byte. It then writes any value to a command byte to launch the transfer. At the control byte's address the host reads back a status byte, which shows whether a transfer is running and whether the controller is signalling an interrupt.

A transfer holds the controller select for a fixed number of cycles, set by a parameter. On a read, the controller's data is captured into a read latch on the last of those cycles. The read latch is a separate register from the write latch. The same host offsets read the read latch and write the write latch, so the host never reads back the value it wrote. The bridge also drives the controller's active-low reset from a bit in the control byte.

Host map: offset 0 writes the write-latch low byte and reads the read-latch low byte. Offset 1 does the same for the high bytes. Offset 2 writes the control byte and reads the status byte. Offset 3 is the command byte; it is write-only and reads as zero.

Top module: `lan_reg_bridge`

## Requirements
- R1: After `rst_n` the control byte is 0x00, so `lan_rst_n` is 0. `lan_sel` is 0, the read latch is 0x0000, and the status byte reads 0x10 while `lan_irq_n` is 1.
- R2: Control bit 3 drives `lan_rst_n`: 0 holds the controller in reset and 1 releases it.
- R3: A host write of any data value to offset 3 starts a transfer when the bridge is idle and control bit 3 is 1. `lan_sel` rises at the next clock edge and stays high for exactly XFER_CYCLES cycles.
- R4: Throughout a transfer, `lan_rap` equals the control bit 0 that was in effect at launch (1 = address port, 0 = data port). `lan_rd` equals the control bit 1 in effect at launch (1 = read from the controller, 0 = write to it).
- R5: In a write transfer `lan_wdata` carries the write latch {offset 1, offset 0} as it stood at launch. A write transfer leaves the read latch unchanged.
- R6: In a read transfer the read latch takes `lan_rdata` at the clock edge that ends the transfer. The host reads the latch at offsets 0 (low byte) and 1 (high byte).
- R7: The status byte shows the transfer-running flag on bit 5 and the level of `lan_irq_n` on bit 4, where 0 means an interrupt is pending. All other status bits read 0.
- R8: Reads at offsets 0 and 1 return the read latch and never the write latch.
- R9: A command write that arrives while a transfer is running is ignored: the running transfer still lasts XFER_CYCLES cycles.
- R10: While control bit 3 is 0, command writes start nothing and the busy flag is 0. Clearing bit 3 during a transfer ends it at that same edge, and a read aborted this way leaves the read latch unchanged.
- R11: Host writes to the write latch or the control byte during a transfer do not change `lan_wdata`, `lan_rap` or `lan_rd` until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = host write, 0 = host read |
| bus_addr | input | 2 | Host byte offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| lan_sel | output | 1 | Controller select, high during a transfer |
| lan_rap | output | 1 | 1 = address port, 0 = data port |
| lan_rd | output | 1 | 1 = read from controller, 0 = write to it |
| lan_wdata | output | 16 | Data driven to the controller |
| lan_rdata | input | 16 | Data returned by the controller |
| lan_irq_n | input | 1 | Controller interrupt, active low |
| lan_rst_n | output | 1 | Controller reset, active low |

## Verification
The hardest case to reach from the ports is the abort: clearing the reset bit partway through a read. The abort must end the transfer early and must not touch the read latch. The bench first stores a value in the stub register file through a normal write transfer, with a different value already in the read latch. It then launches a read and lands a control write on the second transfer cycle. It counts the select cycles and reads back the read latch to confirm that the old value is still there. A similar timed write to the write latch, during a write transfer, shows that the controller sees only the value staged at launch.

// File: rtl/lan_reg_bridge.sv
module lan_reg_bridge #(
  parameter int XFER_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        lan_sel,
  output logic        lan_rap,
  output logic        lan_rd,
  output logic [15:0] lan_wdata,
  input  logic [15:0] lan_rdata,
  input  logic        lan_irq_n,
  output logic        lan_rst_n
);
  localparam int CNT_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_CYCLES - 1);
  localparam logic [1:0] OFS_LO = 2'd0, OFS_HI = 2'd1, OFS_CTL = 2'd2, OFS_CMD = 2'd3;

  logic [7:0]       wlat_lo, wlat_hi;
  logic [15:0]      rlat;
  logic             sel_rap, sel_rd, run_n;
  logic             busy, x_rap, x_rd;
  logic [15:0]      x_data;
  logic [CNT_W-1:0] cnt;

  wire host_wr = bus_sel & bus_wr;
  wire wr_lo   = host_wr & (bus_addr == OFS_LO);
  wire wr_hi   = host_wr & (bus_addr == OFS_HI);
  wire wr_ctl  = host_wr & (bus_addr == OFS_CTL);
  wire wr_cmd  = host_wr & (bus_addr == OFS_CMD);
  wire run_nxt = wr_ctl ? bus_wdata[3] : run_n;
  wire launch  = wr_cmd & ~busy & run_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlat_lo <= '0;
      wlat_hi <= '0;
      rlat    <= '0;
      sel_rap <= 1'b0;
      sel_rd  <= 1'b0;
      run_n   <= 1'b0;
      busy    <= 1'b0;
      x_rap   <= 1'b0;
      x_rd    <= 1'b0;
      x_data  <= '0;
      cnt     <= '0;
    end else begin
      if (wr_lo) wlat_lo <= bus_wdata;
      if (wr_hi) wlat_hi <= bus_wdata;
      if (wr_ctl) begin
        sel_rap <= bus_wdata[0];
        sel_rd  <= bus_wdata[1];
        run_n   <= bus_wdata[3];
      end
      if (!run_nxt) begin
        busy <= 1'b0;
      end else if (launch) begin
        busy   <= 1'b1;
        cnt    <= CNT_LAST;
        x_rap  <= sel_rap;
        x_rd   <= sel_rd;
        x_data <= {wlat_hi, wlat_lo};
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (x_rd) rlat <= lan_rdata;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign lan_sel   = busy;
  assign lan_rap   = x_rap;
  assign lan_rd    = x_rd;
  assign lan_wdata = x_data;
  assign lan_rst_n = run_n;

  always_comb begin
    case (bus_addr)
      OFS_LO:  bus_rdata = rlat[7:0];
      OFS_HI:  bus_rdata = rlat[15:8];
      OFS_CTL: bus_rdata = {2'b00, busy, lan_irq_n, 4'b0000};
      default: bus_rdata = 8'h00;
    endcase
  end

  // R3
  launch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !lan_sel && lan_rst_n && !(wr_ctl)) |=> lan_sel);

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lan_rst_n |-> !lan_sel);

  // R11
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lan_sel && $past(lan_sel)) |-> ($stable(lan_rap) && $stable(lan_rd) && $stable(lan_wdata)));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lan_sel) && lan_rst_n && $past(lan_rd)) |-> (rlat == $past(lan_rdata)));

  // R5
  rlat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(lan_sel) && $past(lan_rd)) |-> $stable(rlat));
endmodule

// File: tb/test_lan_reg_bridge.sv
module test_lan_reg_bridge;
  localparam int XFER = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        lan_sel, lan_rap, lan_rd, lan_rst_n;
  logic [15:0] lan_wdata, lan_rdata;
  logic        lan_irq_n = 1'b1;

  int checks = 0, fails = 0, sel_hi = 0;

  always #4 clk = ~clk;

  lan_reg_bridge #(.XFER_CYCLES(XFER)) i_lan_reg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lan_sel(lan_sel), .lan_rap(lan_rap), .lan_rd(lan_rd),
    .lan_wdata(lan_wdata), .lan_rdata(lan_rdata), .lan_irq_n(lan_irq_n),
    .lan_rst_n(lan_rst_n));

  // controller stub: pointer plus four data registers
  logic [1:0]  stub_rap;
  logic [15:0] stub_regs [4];
  always @(posedge clk) begin
    if (!lan_rst_n) begin
      stub_rap <= '0;
      for (int i = 0; i < 4; i++) stub_regs[i] <= '0;
    end else if (lan_sel && !lan_rd) begin
      if (lan_rap) stub_rap <= lan_wdata[1:0];
      else stub_regs[stub_rap] <= lan_wdata;
    end
  end
  assign lan_rdata = lan_rap ? {14'b0, stub_rap} : stub_regs[stub_rap];

  always begin
    @(posedge clk);
    #2;
    if (lan_sel) sel_hi++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    while (lan_sel) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_wlat(input logic [15:0] v);
    bus_write(2'd0, v[7:0]);
    bus_write(2'd1, v[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 lan_rst_n", lan_rst_n, 0);
    chk("R1 lan_sel", lan_sel, 0);
    bus_read(2'd2, d); chk("R1 status", d, 8'h10);
    bus_read(2'd0, d); chk("R1 rlat lo", d, 0);
    bus_read(2'd1, d); chk("R1 rlat hi", d, 0);
  endtask

  task automatic t_held_in_reset();
    int s;
    logic [7:0] d;
    s = sel_hi;
    bus_write(2'd3, 8'hFF);
    repeat (6) @(negedge clk);
    chk("R10 no launch in reset", sel_hi - s, 0);
    bus_read(2'd2, d); chk("R10 busy 0 in reset", d, 8'h10);
  endtask

  task automatic t_release();
    bus_write(2'd2, 8'h08);
    chk("R2 reset released", lan_rst_n, 1);
  endtask

  task automatic t_set_pointer();
    int s;
    logic [7:0] d;
    load_wlat(16'h0002);
    bus_write(2'd2, 8'h09);
    s = sel_hi;
    bus_write(2'd3, 8'hA5);
    chk("R3 sel rises", lan_sel, 1);
    chk("R4 target address port", lan_rap, 1);
    chk("R4 direction write", lan_rd, 0);
    chk("R5 wdata", lan_wdata, 16'h0002);
    bus_read(2'd2, d); chk("R7 status busy", d, 8'h30);
    wait_idle();
    chk("R3 length", sel_hi - s, XFER);
    bus_read(2'd2, d); chk("R7 status idle", d, 8'h10);
  endtask

  task automatic t_write_data();
    int s;
    load_wlat(16'h1234);
    bus_write(2'd2, 8'h08);
    s = sel_hi;
    bus_write(2'd3, 8'h00);
    chk("R4 target data port", lan_rap, 0);
    wait_idle();
    chk("R3 any value launches", sel_hi - s, XFER);
  endtask

  task automatic t_read_data();
    logic [7:0] d;
    load_wlat(16'hBEEF);
    bus_write(2'd2, 8'h0A);
    bus_write(2'd3, 8'h3C);
    chk("R4 direction read", lan_rd, 1);
    wait_idle();
    bus_read(2'd0, d); chk("R6 R8 rlat lo", d, 8'h34);
    bus_read(2'd1, d); chk("R6 R8 rlat hi", d, 8'h12);
  endtask

  task automatic t_cmd_while_busy();
    int s;
    logic [7:0] d;
    bus_write(2'd2, 8'h08);
    s = sel_hi;
    bus_write(2'd3, 8'h01);
    bus_write(2'd3, 8'h02);
    wait_idle();
    chk("R9 second command ignored", sel_hi - s, XFER);
    bus_read(2'd0, d); chk("R5 write keeps rlat", d, 8'h34);
  endtask

  task automatic t_snapshot();
    logic [7:0] d;
    load_wlat(16'h5555);
    bus_write(2'd2, 8'h08);
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'h00);
    chk("R11 still busy", lan_sel, 1);
    chk("R11 wdata frozen", lan_wdata, 16'h5555);
    wait_idle();
    bus_write(2'd2, 8'h0A);
    bus_write(2'd3, 8'h00);
    wait_idle();
    bus_read(2'd0, d); chk("R11 stored lo", d, 8'h55);
    bus_read(2'd1, d); chk("R11 stored hi", d, 8'h55);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    lan_irq_n = 1'b0;
    bus_read(2'd2, d); chk("R7 irq pending", d, 8'h00);
    lan_irq_n = 1'b1;
    bus_read(2'd2, d); chk("R7 irq clear", d, 8'h10);
    bus_read(2'd3, d); chk("R7 command reads zero", d, 8'h00);
  endtask

  task automatic t_abort();
    int s;
    logic [7:0] d;
    load_wlat(16'h7777);
    bus_write(2'd2, 8'h08);
    bus_write(2'd3, 8'h00);
    wait_idle();
    bus_write(2'd2, 8'h0A);
    s = sel_hi;
    bus_write(2'd3, 8'h00);
    bus_write(2'd2, 8'h02);
    chk("R10 abort drops sel", lan_sel, 0);
    chk("R10 abort asserts reset", lan_rst_n, 0);
    repeat (4) @(negedge clk);
    chk("R10 abort length", sel_hi - s, 2);
    bus_read(2'd0, d); chk("R10 no capture lo", d, 8'h55);
    bus_read(2'd2, d); chk("R10 status idle", d, 8'h10);
    bus_write(2'd2, 8'h08);
    chk("R2 released again", lan_rst_n, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_held_in_reset();
        t_release();
        t_set_pointer();
        t_write_data();
        t_read_data();
        t_cmd_while_busy();
        t_snapshot();
        t_irq();
        t_abort();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule